// File: doc/BRIEF.md
# Bidirectional Barrel Shifter on a Single Rotate Core

This block is a purely combinational word shifter. It covers the three integer shift operations of a 32-bit RISC-style datapath: logical left, logical right and arithmetic right. All three run through one rotate-right network. The network has one rotate stage for each bit of the shift amount, with the stages sized 1, 2, 4, 8 and 16 positions.

A left shift needs no separate network and no word reversal. Each amount bit is XOR-ed with the direction bit, and one fixed single-position rotate stage is enabled by the direction bit. Together these rotate the word right by the two's-complement of the amount, which is the same as rotating it left by the amount. A fill stage follows the rotator. It clears the bits that wrapped around, or replaces them with copies of the sign bit, so the rotate result becomes a true shift.

The operand, amount, direction bit and arithmetic bit are applied as inputs, and the result is read in the same cycle. A parameter chooses whether the extra single-position stage sits before or after the five main stages.

Top module: `rotsh_shifter`

## Requirements
- R1: With dir_left_i = 0 and arith_i = 0, result_o equals operand_i shifted right by amount_i, and the vacated top bits are 0.
- R2: With dir_left_i = 0 and arith_i = 1, result_o equals operand_i shifted right by amount_i, and each vacated top bit equals operand_i[31].
- R3: With dir_left_i = 1, result_o equals operand_i shifted left by amount_i, and the vacated bottom bits are 0.
- R4: With dir_left_i = 1, arith_i has no effect on result_o.
- R5: When amount_i = 0, result_o equals operand_i for all four settings of dir_left_i and arith_i.
- R6: At amount_i = 31, the results are as follows. A logical right shift yields operand_i[31] in bit 0 and zero elsewhere. A left shift yields operand_i[0] in bit 31 and zero elsewhere. An arithmetic right shift yields 32 copies of operand_i[31].
- R7: Placing the single-position stage before the main stages (EXTRA_FIRST = 1) or after them (EXTRA_FIRST = 0) gives the same result_o for every input.
- R8: result_o depends only on the current inputs and settles within the same cycle that the inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Word to be shifted |
| amount_i | input | 5 | Shift distance, 0 to 31 |
| dir_left_i | input | 1 | 1 selects a left shift, 0 selects a right shift |
| arith_i | input | 1 | For right shifts, 1 fills with the sign bit and 0 fills with zeros |
| result_o | output | 32 | Shifted word |

## Verification
The bench builds two copies of the block side by side. Both use WIDTH = 32. One has the single-position stage after the main stages (EXTRA_FIRST = 0), and the other has it in front (EXTRA_FIRST = 1). Every vector goes to both copies and both are compared with the language's own shift operators. This brings the placement equivalence of R7 within reach, together with all 32 amounts in each direction, including the wrap from a complemented 31 back to 0 at amount zero.

// File: rtl/rotsh_pkg.sv
package rotsh_pkg;

    typedef enum logic [1:0] {
        FILL_ZERO_HI = 2'd0,
        FILL_SIGN_HI = 2'd1,
        FILL_ZERO_LO = 2'd2
    } fill_kind_e;

endpackage

// File: rtl/rotsh_ctrl.sv
module rotsh_ctrl
    import rotsh_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0] amount_i,
    input  logic             dir_left_i,
    input  logic             arith_i,
    output logic [AMT_W-1:0] stage_sel_o,
    output logic             extra_en_o,
    output fill_kind_e       fill_kind_o,
    output logic [WIDTH-1:0] keep_mask_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    assign stage_sel_o = amount_i ^ {AMT_W{dir_left_i}};
    assign extra_en_o  = dir_left_i;

    always_comb begin
        if (dir_left_i) begin
            fill_kind_o = FILL_ZERO_LO;
            keep_mask_o = ALL_ONES << amount_i;
        end else begin
            fill_kind_o = arith_i ? FILL_SIGN_HI : FILL_ZERO_HI;
            keep_mask_o = ALL_ONES >> amount_i;
        end
    end

endmodule

// File: rtl/rotsh_rotator.sv
module rotsh_rotator #(
    parameter int WIDTH       = 32,
    parameter bit EXTRA_FIRST = 1'b0,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] stage_sel_i,
    input  logic             extra_en_i,
    output logic [WIDTH-1:0] data_o
);

    logic [WIDTH-1:0] lvl [0:AMT_W+1];

    assign lvl[0] = data_i;

    generate
        if (EXTRA_FIRST) begin : g_extra_front
            assign lvl[1] = extra_en_i ? {lvl[0][0], lvl[0][WIDTH-1:1]} : lvl[0];
            for (genvar k = 0; k < AMT_W; k++) begin : g_stage
                localparam int S = 2 ** k;
                assign lvl[k+2] = stage_sel_i[k] ?
                    {lvl[k+1][S-1:0], lvl[k+1][WIDTH-1:S]} : lvl[k+1];
            end
        end else begin : g_extra_back
            for (genvar k = 0; k < AMT_W; k++) begin : g_stage
                localparam int S = 2 ** k;
                assign lvl[k+1] = stage_sel_i[k] ?
                    {lvl[k][S-1:0], lvl[k][WIDTH-1:S]} : lvl[k];
            end
            assign lvl[AMT_W+1] = extra_en_i ?
                {lvl[AMT_W][0], lvl[AMT_W][WIDTH-1:1]} : lvl[AMT_W];
        end
    endgenerate

    assign data_o = lvl[AMT_W+1];

    always_comb begin
        int unsigned eff;
        logic [WIDTH-1:0] expect_rot;
        eff = (int'(stage_sel_i) + int'(extra_en_i)) % WIDTH;
        expect_rot = (data_i >> eff) | ((eff == 0) ? '0 : (data_i << (WIDTH - eff)));
        // R7
        rot_total_chk: assert (data_o == expect_rot)
            else $error("rotator output differs from total rotation");
    end

endmodule

// File: rtl/rotsh_fill.sv
module rotsh_fill
    import rotsh_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rotated_i,
    input  logic [WIDTH-1:0] keep_mask_i,
    input  fill_kind_e       fill_kind_i,
    input  logic             sign_i,
    output logic [WIDTH-1:0] result_o
);

    always_comb begin
        unique case (fill_kind_i)
            FILL_ZERO_HI: result_o = rotated_i & keep_mask_i;
            FILL_SIGN_HI: result_o = (rotated_i & keep_mask_i) |
                                     ({WIDTH{sign_i}} & ~keep_mask_i);
            FILL_ZERO_LO: result_o = rotated_i & keep_mask_i;
            default:      result_o = rotated_i & keep_mask_i;
        endcase
    end

    always_comb begin
        // R1
        fill_keep_chk: assert ((result_o & keep_mask_i) == (rotated_i & keep_mask_i))
            else $error("fill stage altered a kept bit");
    end

endmodule

// File: rtl/rotsh_shifter.sv
module rotsh_shifter
    import rotsh_pkg::*;
#(
    parameter int WIDTH       = 32,
    parameter bit EXTRA_FIRST = 1'b0,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic             dir_left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] result_o
);

    logic [AMT_W-1:0] stage_sel;
    logic             extra_en;
    fill_kind_e       fill_kind;
    logic [WIDTH-1:0] keep_mask;
    logic [WIDTH-1:0] rotated;

    rotsh_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .amount_i    (amount_i),
        .dir_left_i  (dir_left_i),
        .arith_i     (arith_i),
        .stage_sel_o (stage_sel),
        .extra_en_o  (extra_en),
        .fill_kind_o (fill_kind),
        .keep_mask_o (keep_mask)
    );

    rotsh_rotator #(.WIDTH(WIDTH), .EXTRA_FIRST(EXTRA_FIRST)) rot_i (
        .data_i      (operand_i),
        .stage_sel_i (stage_sel),
        .extra_en_i  (extra_en),
        .data_o      (rotated)
    );

    rotsh_fill #(.WIDTH(WIDTH)) fill_i (
        .rotated_i   (rotated),
        .keep_mask_i (keep_mask),
        .fill_kind_i (fill_kind),
        .sign_i      (operand_i[WIDTH-1]),
        .result_o    (result_o)
    );

    always_comb begin
        if (!dir_left_i && !arith_i) begin
            // R1
            srl_ref_chk: assert (result_o == (operand_i >> amount_i))
                else $error("logical right shift mismatch");
        end
        if (!dir_left_i && arith_i) begin
            // R2
            sra_ref_chk: assert (result_o == WIDTH'($signed(operand_i) >>> amount_i))
                else $error("arithmetic right shift mismatch");
        end
        if (dir_left_i) begin
            // R3
            sll_ref_chk: assert (result_o == (operand_i << amount_i))
                else $error("left shift mismatch");
        end
        if (amount_i == '0) begin
            // R5
            zero_amt_chk: assert (result_o == operand_i)
                else $error("zero amount did not pass operand through");
        end
    end

endmodule

// File: tb/rotsh_shifter_tb_top.sv
module rotsh_shifter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] operand;
    logic [4:0]  amount;
    logic        dir_left;
    logic        arith;
    logic [31:0] res_back;
    logic [31:0] res_front;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    rotsh_shifter #(.WIDTH(32), .EXTRA_FIRST(1'b0)) dut_i (
        .operand_i (operand), .amount_i (amount), .dir_left_i (dir_left),
        .arith_i (arith), .result_o (res_back)
    );

    rotsh_shifter #(.WIDTH(32), .EXTRA_FIRST(1'b1)) dut_front_i (
        .operand_i (operand), .amount_i (amount), .dir_left_i (dir_left),
        .arith_i (arith), .result_o (res_front)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (op=%h amt=%0d left=%0b arith=%0b)",
                     req, got, exp, operand, amount, dir_left, arith);
        end
    endtask

    task automatic apply(input logic [31:0] op, input int amt, input bit l, input bit a);
        @(posedge clk);
        operand  = op;
        amount   = 5'(amt);
        dir_left = l;
        arith    = a;
        @(negedge clk);
    endtask

    function automatic logic [31:0] ref_shift(input logic [31:0] op, input int amt,
                                              input bit l, input bit a);
        if (l)      return op << amt;
        else if (a) return 32'($signed(op) >>> amt);
        else        return op >> amt;
    endfunction

    task automatic t_reset_state();
        apply(32'h0, 0, 1'b0, 1'b0);
        check("R5 idle", res_back, 32'h0);
        check("R7 idle", res_front, 32'h0);
    endtask

    task automatic t_amount_zero();
        logic [31:0] pats [4] = '{32'h8000_0001, 32'hFFFF_FFFF, 32'h1234_5678, 32'hC3A5_5A3C};
        foreach (pats[i]) begin
            for (int m = 0; m < 4; m++) begin
                apply(pats[i], 0, m[1], m[0]);
                check("R5", res_back, pats[i]);
                check("R7", res_front, pats[i]);
            end
        end
    endtask

    task automatic t_sweep(input bit l, input bit a, input string req);
        for (int r = 0; r < 6; r++) begin
            logic [31:0] op;
            op = (r == 0) ? 32'h8000_0000 : (r == 1) ? 32'h7FFF_FFFF : $urandom();
            for (int s = 0; s < 32; s++) begin
                apply(op, s, l, a);
                check(req, res_back, ref_shift(op, s, l, a));
                check("R7", res_front, res_back);
            end
        end
    endtask

    task automatic t_arith_ignored_left();
        for (int r = 0; r < 8; r++) begin
            logic [31:0] op;
            logic [31:0] first;
            op = $urandom() | 32'h8000_0000;
            apply(op, r * 4 + 1, 1'b1, 1'b0);
            first = res_back;
            apply(op, r * 4 + 1, 1'b1, 1'b1);
            check("R4", res_back, first);
            check("R4", res_back, op << (r * 4 + 1));
        end
    endtask

    task automatic t_max_amount();
        apply(32'h8000_0000, 31, 1'b0, 1'b0);
        check("R6 srl", res_back, 32'h0000_0001);
        apply(32'h7FFF_FFFF, 31, 1'b0, 1'b0);
        check("R6 srl", res_back, 32'h0);
        apply(32'h0000_0001, 31, 1'b1, 1'b0);
        check("R6 sll", res_back, 32'h8000_0000);
        apply(32'hFFFF_FFFE, 31, 1'b1, 1'b0);
        check("R6 sll", res_back, 32'h0);
        apply(32'h8000_0000, 31, 1'b0, 1'b1);
        check("R6 sra", res_back, 32'hFFFF_FFFF);
        apply(32'h7FFF_FFFF, 31, 1'b0, 1'b1);
        check("R6 sra", res_back, 32'h0);
        check("R7", res_front, res_back);
    endtask

    task automatic t_same_cycle();
        @(posedge clk);
        operand = 32'hF000_000F; amount = 5'd4; dir_left = 1'b1; arith = 1'b0;
        #1;
        check("R8", res_back, 32'h0000_00F0);
        operand = 32'hF000_000F; amount = 5'd4; dir_left = 1'b0; arith = 1'b1;
        #1;
        check("R8", res_back, 32'hFF00_0000);
    endtask

    initial begin
        operand = '0; amount = '0; dir_left = 1'b0; arith = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_amount_zero();
        t_sweep(1'b0, 1'b0, "R1");
        t_sweep(1'b0, 1'b1, "R2");
        t_sweep(1'b1, 1'b0, "R3");
        t_sweep(1'b1, 1'b1, "R4");
        t_arith_ignored_left();
        t_max_amount();
        t_same_cycle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule